// File: doc/BRIEF.md
# Event-Started Single-Channel DMA Mover

This block is one DMA channel that copies a block of bytes, one 32-bit word at a time, from a source address to a destination address over a simple request/acknowledge memory port. The copy is launched only when the channel is armed and a chosen start event fires. Seven of the start events are hardware pulses, such as blanking edges, timers, a sound request or a sprite engine finishing. The eighth is a software start strobe.

For each word the channel does a read and then a write. After the write, the source pointer moves on by 0 or 4 bytes and the destination pointer moves on by a power-of-two stride. The remaining byte count drops by 4, and a programmed count of zero means the largest transfer the count field can describe. At the end the channel can store the final pointers back into its address registers. A chip-wide forced-stop input ends any activity at once.

A controller first loads the two address registers and the byte count with `cfg_load`. It then sets the mode inputs, raises `enable` and waits for `done`. The mode inputs are levels and are held steady during a transfer.

The state machine has five states:
- IDLE: nothing to do.
- ARMED: waiting for the start event.
- READ: reading the source word.
- WRITE: writing the destination word.
- FINISH: the count is used up.

Its transitions are:
- IDLE→ARMED when `enable` is 1.
- ARMED→IDLE when `enable` is 0.
- ARMED→READ when the selected event fires.
- READ→WRITE on acknowledge.
- WRITE→READ on acknowledge while words remain.
- WRITE→FINISH on acknowledge of the last word.
- FINISH→IDLE unconditionally.
- Any state→IDLE while `force_stop` is 1.

Top module: `trig_dma_chan`

## Requirements
- R1: After reset `busy`, `waiting`, `done` and `mem_req` are 0.
- R2: With `enable`=1 and `force_stop`=0, `waiting` is 1 one cycle later. With `enable`=0, no event starts a transfer. `waiting` and `busy` are never 1 together.
- R3: `trig_sel` picks the start event: 0 `evt[0]` vertical blank start, 1 `evt[1]` vertical blank end, 2 `evt[2]` horizontal blank start, 3 `evt[3]` timer 0, 4 `evt[4]` timer 1, 5 `evt[5]` sound request, 6 `evt[6]` sprite draw end, 7 `sw_start`. Pulses on the events that are not selected leave the channel waiting and issue no request. `busy` rises only out of the waiting state.
- R4: Each word is a read (`mem_we`=0) followed by a write (`mem_we`=1). The write carries the 32-bit data of the preceding read. Address and direction hold steady while a request waits for `mem_ack`.
- R5: With `rd_inc`=0 every read uses the same address. With `rd_inc`=1 the read address grows by 4 per word, wrapping modulo 2^27.
- R6: A `wr_stride` code of 0 keeps the write address fixed. A code k from 1 to 7 advances it by 2^k bytes per word (2 to 128), wrapping modulo 2^27.
- R7: A count of N bytes moves ceil(N/4) words. A count of 0 moves 2^CNT_W bytes.
- R8: `done` is a one-cycle pulse, given after the last write is acknowledged. `busy` is 0 in the following cycle.
- R9: On completion `rd_addr_q` takes the next read address if `rd_upd`=1 and otherwise keeps its loaded value. `wr_addr_q` behaves the same way under `wr_upd`.
- R10: While `force_stop`=1, `mem_req` is 0. `busy` is 0 from the next cycle, no `done` is given, the address registers are not updated, and the channel does not arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel permission level |
| force_stop | input | 1 | Global forced stop |
| trig_sel | input | 3 | Start event select |
| evt | input | 7 | Hardware start event pulses |
| sw_start | input | 1 | Software start strobe |
| rd_inc | input | 1 | Read step: 0 none, 1 four bytes |
| wr_stride | input | 3 | Write step code |
| rd_upd | input | 1 | Store final read address at completion |
| wr_upd | input | 1 | Store final write address at completion |
| cfg_load | input | 1 | Load address and count registers (ignored while busy) |
| rd_addr_in | input | 27 | Read address to load |
| wr_addr_in | input | 27 | Write address to load |
| byte_cnt_in | input | CNT_W | Byte count to load |
| rd_addr_q | output | 27 | Read address register |
| wr_addr_q | output | 27 | Write address register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 27 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted / data valid |
| busy | output | 1 | Operating flag |
| waiting | output | 1 | Armed, waiting for start event |
| done | output | 1 | One-cycle completion pulse |

## Verification
`waiting` follows `enable` one edge later. A selected event pulse raises `mem_req` one edge after it is sampled. The memory model in the bench answers every request one cycle after it appears, so each word takes four cycles. `done` comes in the cycle after the last write acknowledge, and the stored addresses and the low `busy` are visible one edge after that. Memory traffic is checked by order rather than by cycle. The driver queues every expected read and write, and a monitor compares them at the falling edge whenever request and acknowledge are both high. The status and address checks wait for the `done` pulse and then sample one falling edge later. The forced-stop checks sample on the falling edge after the stop is applied.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } tdma_state_e;

    localparam int SEL_W     = 3;
    localparam int HW_EVENTS = (1 << SEL_W) - 1;
    localparam int STRIDE_W  = 3;
    localparam int WORD_B    = 4;
endpackage

// File: rtl/tdma_trig_sel.sv
module tdma_trig_sel #(
    parameter int SEL_W = 3,
    localparam int NSRC = 1 << SEL_W
) (
    input  logic [NSRC-2:0]  evt,
    input  logic             sw_start,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [NSRC-1:0] src;

    // Hardware events occupy the low codes; the all-ones code is software.
    generate
        for (genvar g = 0; g < NSRC - 1; g++) begin : g_hw
            assign src[g] = evt[g];
        end
    endgenerate
    assign src[NSRC-1] = sw_start;
    assign hit = src[sel];
endmodule

// File: rtl/tdma_addr_step.sv
module tdma_addr_step #(
    parameter int AW     = 27,
    parameter int CODE_W = 3
) (
    input  logic [AW-1:0]     base,
    input  logic [CODE_W-1:0] code,
    output logic [AW-1:0]     next
);
    logic [AW-1:0] step;

    // Code 0 holds the address; code k adds 2^k bytes.
    always_comb begin
        if (code == '0) step = '0;
        else            step = AW'(1) << code;
    end
    assign next = base + step;
endmodule

// File: rtl/tdma_fsm.sv
module tdma_fsm
    import tdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic force_stop,
    input  logic hit,
    input  logic mem_ack,
    input  logic last_word,
    output logic launch,
    output logic mem_req,
    output logic mem_we,
    output logic busy,
    output logic waiting,
    output logic done
);
    tdma_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (force_stop) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (enable) state_n = ST_ARMED;
                ST_ARMED:  if (!enable) state_n = ST_IDLE;
                           else if (hit) state_n = ST_READ;
                ST_READ:   if (mem_ack) state_n = ST_WRITE;
                ST_WRITE:  if (mem_ack) state_n = last_word ? ST_FINISH : ST_READ;
                ST_FINISH: state_n = ST_IDLE;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        launch  = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        busy    = 1'b0;
        waiting = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_ARMED: begin
                waiting = 1'b1;
                launch  = enable && hit && !force_stop;
            end
            ST_READ: begin
                busy    = 1'b1;
                mem_req = !force_stop;
            end
            ST_WRITE: begin
                busy    = 1'b1;
                mem_req = !force_stop;
                mem_we  = 1'b1;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = !force_stop;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trig_dma_chan.sv
module trig_dma_chan
    import tdma_pkg::*;
#(
    parameter int AW    = 27,
    parameter int DW    = 32,
    parameter int CNT_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                force_stop,
    input  logic [SEL_W-1:0]    trig_sel,
    input  logic [HW_EVENTS-1:0] evt,
    input  logic                sw_start,
    input  logic                rd_inc,
    input  logic [STRIDE_W-1:0] wr_stride,
    input  logic                rd_upd,
    input  logic                wr_upd,
    input  logic                cfg_load,
    input  logic [AW-1:0]       rd_addr_in,
    input  logic [AW-1:0]       wr_addr_in,
    input  logic [CNT_W-1:0]    byte_cnt_in,
    output logic [AW-1:0]       rd_addr_q,
    output logic [AW-1:0]       wr_addr_q,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    input  logic                mem_ack,
    output logic                busy,
    output logic                waiting,
    output logic                done
);
    localparam int REM_W = CNT_W + 1;
    localparam logic [REM_W-1:0] FULL_LEN = REM_W'(1) << CNT_W;
    localparam logic [REM_W-1:0] WORD_LEN = REM_W'(WORD_B);

    logic                hit, launch, last_word;
    logic                rd_ack, wr_ack;
    logic [AW-1:0]       rd_cur, wr_cur, rd_next, wr_next;
    logic [CNT_W-1:0]    cnt_cfg;
    logic [REM_W-1:0]    cnt_rem;
    logic [DW-1:0]       data_q;
    logic [STRIDE_W-1:0] rd_code;

    tdma_trig_sel #(.SEL_W(SEL_W)) u_sel (
        .evt(evt), .sw_start(sw_start), .sel(trig_sel), .hit(hit)
    );

    assign rd_code = rd_inc ? STRIDE_W'(2) : '0;

    tdma_addr_step #(.AW(AW), .CODE_W(STRIDE_W)) u_rd_step (
        .base(rd_cur), .code(rd_code), .next(rd_next)
    );
    tdma_addr_step #(.AW(AW), .CODE_W(STRIDE_W)) u_wr_step (
        .base(wr_cur), .code(wr_stride), .next(wr_next)
    );

    assign last_word = cnt_rem <= WORD_LEN;

    tdma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .force_stop(force_stop),
        .hit(hit), .mem_ack(mem_ack), .last_word(last_word),
        .launch(launch), .mem_req(mem_req), .mem_we(mem_we),
        .busy(busy), .waiting(waiting), .done(done)
    );

    assign rd_ack    = mem_req && !mem_we && mem_ack;
    assign wr_ack    = mem_req && mem_we && mem_ack;
    assign mem_addr  = mem_we ? wr_cur : rd_cur;
    assign mem_wdata = data_q;

    // Programmed registers; the completion pulse may store final pointers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            cnt_cfg   <= '0;
        end else if (cfg_load && !busy) begin
            rd_addr_q <= rd_addr_in;
            wr_addr_q <= wr_addr_in;
            cnt_cfg   <= byte_cnt_in;
        end else if (done) begin
            if (rd_upd) rd_addr_q <= rd_cur;
            if (wr_upd) wr_addr_q <= wr_cur;
        end
    end

    // Working pointers, remaining count and the word in flight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cur  <= '0;
            wr_cur  <= '0;
            cnt_rem <= '0;
            data_q  <= '0;
        end else if (launch) begin
            rd_cur  <= rd_addr_q;
            wr_cur  <= wr_addr_q;
            cnt_rem <= (cnt_cfg == '0) ? FULL_LEN : REM_W'(cnt_cfg);
        end else if (rd_ack) begin
            data_q <= mem_rdata;
        end else if (wr_ack) begin
            rd_cur  <= rd_next;
            wr_cur  <= wr_next;
            cnt_rem <= last_word ? '0 : cnt_rem - WORD_LEN;
        end
    end
endmodule

// File: rtl/tdma_chk.sv
module tdma_chk #(
    parameter int AW = 27
) (
    input logic          clk,
    input logic          rst_n,
    input logic          force_stop,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          waiting,
    input logic          done
);
    // R2
    excl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && waiting));

    // R3
    start_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(waiting));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (force_stop || (mem_req && $stable(mem_addr) && $stable(mem_we))));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10
    stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_stop |=> (!busy && !done && !waiting));
endmodule

bind trig_dma_chan tdma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .force_stop(force_stop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .busy(busy), .waiting(waiting), .done(done)
);

// File: tb/trig_dma_chan_test.sv
`timescale 1ns/1ps
module trig_dma_chan_test;
    localparam int AW    = 27;
    localparam int CNT_W = 8;

    logic clk = 0, rst_n = 0;
    logic enable = 0, force_stop = 0, sw_start = 0, rd_inc = 0;
    logic rd_upd = 0, wr_upd = 0, cfg_load = 0;
    logic [2:0] trig_sel = 0, wr_stride = 0;
    logic [6:0] evt = 0;
    logic [AW-1:0] rd_addr_in = 0, wr_addr_in = 0, rd_addr_q, wr_addr_q, mem_addr;
    logic [CNT_W-1:0] byte_cnt_in = 0;
    logic mem_req, mem_we, mem_ack = 0, busy, waiting, done;
    logic [31:0] mem_wdata, mem_rdata;

    int checks = 0, errors = 0, done_cnt = 0;
    logic [59:0] exp_q[$];

    always #10 clk = ~clk;

    function automatic logic [31:0] mdata(input logic [AW-1:0] a);
        return {a[15:0], ~a[26:11]};
    endfunction

    assign mem_rdata = mdata(mem_addr);

    always @(posedge clk) mem_ack <= mem_req && !mem_ack;

    trig_dma_chan #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .force_stop(force_stop),
        .trig_sel(trig_sel), .evt(evt), .sw_start(sw_start), .rd_inc(rd_inc),
        .wr_stride(wr_stride), .rd_upd(rd_upd), .wr_upd(wr_upd), .cfg_load(cfg_load),
        .rd_addr_in(rd_addr_in), .wr_addr_in(wr_addr_in), .byte_cnt_in(byte_cnt_in),
        .rd_addr_q(rd_addr_q), .wr_addr_q(wr_addr_q), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .waiting(waiting), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare every accepted memory access with the scoreboard head.
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (rst_n && mem_req && mem_ack) begin
            logic [59:0] got;
            got = {mem_we, mem_addr, mem_we ? mem_wdata : mem_rdata};
            if (exp_q.size() == 0) begin
                check(0, "R4/R7 extra access", 64'(got), 64'h0);
            end else begin
                logic [59:0] e;
                e = exp_q.pop_front();
                check(got == e, "R4/R5/R6 access", 64'(got), 64'(e));
            end
        end
    end

    task automatic load_cfg(input logic [AW-1:0] ra, input logic [AW-1:0] wa, input int cnt);
        @(negedge clk);
        rd_addr_in = ra; wr_addr_in = wa; byte_cnt_in = CNT_W'(cnt); cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
    endtask

    // Driver: push the expected read/write pairs for one transfer.
    task automatic push_xfer(input logic [AW-1:0] ra, input logic [AW-1:0] wa, input int cnt,
                             input logic inc, input logic [2:0] code);
        int words;
        int step;
        words = (cnt == 0) ? (1 << CNT_W) / 4 : (cnt + 3) / 4;
        step  = (code == 0) ? 0 : (1 << code);
        for (int i = 0; i < words; i++) begin
            logic [AW-1:0] r, w;
            r = ra + AW'(inc ? 4 * i : 0);
            w = wa + AW'(step * i);
            exp_q.push_back({1'b0, r, mdata(r)});
            exp_q.push_back({1'b1, w, mdata(r)});
        end
    endtask

    task automatic pulse(input int src);
        @(negedge clk);
        if (src == 7) sw_start = 1; else evt[src] = 1;
        @(negedge clk);
        sw_start = 0; evt = 0;
    endtask

    task automatic wait_done(input string req);
        int start;
        start = done_cnt;
        for (int i = 0; i < 3000 && done_cnt == start; i++) @(negedge clk);
        check(done_cnt == start + 1, req, 64'(done_cnt - start), 64'd1);
        @(negedge clk);
        check(busy == 0, "R8 busy clear", 64'(busy), 64'd0);
        check(exp_q.size() == 0, "R7 word count", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic run_xfer(input int src, input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                            input int cnt, input logic inc, input logic [2:0] code,
                            input logic ru, input logic wu, input int words);
        int step;
        step = (code == 0) ? 0 : (1 << code);
        enable = 0;
        load_cfg(ra, wa, cnt);
        trig_sel = 3'(src); rd_inc = inc; wr_stride = code; rd_upd = ru; wr_upd = wu;
        push_xfer(ra, wa, cnt, inc, code);
        enable = 1;
        @(negedge clk);
        check(waiting == 1, "R2 waiting", 64'(waiting), 64'd1);
        pulse(src);
        wait_done("R8 done pulse");
        check(rd_addr_q == (ru ? ra + AW'(inc ? 4 * words : 0) : ra), "R9 rd writeback",
              64'(rd_addr_q), 64'(ru ? ra + AW'(inc ? 4 * words : 0) : ra));
        check(wr_addr_q == (wu ? wa + AW'(step * words) : wa), "R9 wr writeback",
              64'(wr_addr_q), 64'(wu ? wa + AW'(step * words) : wa));
        enable = 0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        check(0, "watchdog", 64'd0, 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && waiting == 0 && done == 0 && mem_req == 0, "R1 reset",
              64'({busy, waiting, done, mem_req}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check(waiting == 0, "R2 idle without enable", 64'(waiting), 64'd0);

        // R2: trigger ignored while disabled
        load_cfg(27'h100, 27'h200, 8);
        trig_sel = 3'd7;
        pulse(7);
        repeat (3) @(negedge clk);
        check(busy == 0 && mem_req == 0, "R2 disabled ignores start", 64'({busy, mem_req}), 64'd0);

        // R3: non-selected events ignored
        trig_sel = 3'd3; enable = 1;
        @(negedge clk);
        pulse(0); pulse(4); pulse(7);
        repeat (2) @(negedge clk);
        check(waiting == 1 && busy == 0 && mem_req == 0, "R3 other events ignored",
              64'({waiting, busy, mem_req}), 64'h4);
        enable = 0;
        @(negedge clk);

        // R3 R5 R6 R9: timer 0, 3 words, read +4, write +8, both update
        run_xfer(3, 27'h0001000, 27'h0002000, 12, 1, 3'd3, 1, 1, 3);
        // R5 R6 R7: software start, 6 bytes -> 2 words, fixed read, stride 128
        run_xfer(7, 27'h0000400, 27'h0003000, 6, 0, 3'd7, 0, 1, 2);
        // R7: count 0 -> full length, read wraps modulo 2^27, stride 2
        run_xfer(0, 27'h7FFFFF0, 27'h0004000, 0, 1, 3'd1, 1, 0, 64);
        // R6: sprite end, single word, write stride code 0
        run_xfer(6, 27'h0000010, 27'h0000020, 4, 1, 3'd0, 1, 1, 1);

        // R10: forced stop in mid-transfer
        begin
            int dstart;
            load_cfg(27'h0005000, 27'h0006000, 40);
            trig_sel = 3'd5; rd_inc = 1; wr_stride = 3'd2; rd_upd = 1; wr_upd = 1;
            push_xfer(27'h0005000, 27'h0006000, 40, 1, 3'd2);
            enable = 1;
            @(negedge clk);
            pulse(5);
            dstart = done_cnt;
            wait (exp_q.size() <= 12);
            @(negedge clk);
            #2 force_stop = 1;
            @(negedge clk);
            check(mem_req == 0, "R10 request dropped", 64'(mem_req), 64'd0);
            check(busy == 0 && waiting == 0, "R10 halted", 64'({busy, waiting}), 64'd0);
            exp_q.delete();
            repeat (3) @(negedge clk);
            check(waiting == 0, "R10 no arming under stop", 64'(waiting), 64'd0);
            check(done_cnt == dstart, "R10 no done", 64'(done_cnt - dstart), 64'd0);
            check(rd_addr_q == 27'h0005000 && wr_addr_q == 27'h0006000, "R10 no writeback",
                  64'({rd_addr_q, wr_addr_q}), 64'({27'h0005000, 27'h0006000}));
            force_stop = 0;
            @(negedge clk);
            @(negedge clk);
            check(waiting == 1, "R2 re-arm after stop", 64'(waiting), 64'd1);
            enable = 0;
            repeat (2) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule